// File: doc/BRIEF.md
# Zero-Negate Conditioned ALU

This block is a purely combinational arithmetic logic unit with two data operands, X and Y, and a six-bit control word. It does not decode an opcode. Each operand is conditioned in two steps: it can first be replaced by zero, and the result can then be inverted bit by bit. The two conditioned operands go to a single core. The core produces either their sum or their bitwise AND. The core result can then be inverted before it leaves the block.

By choosing these steps, 18 useful operations come out of the same datapath. They are constants, pass-through, bitwise NOT, two's-complement negation, increment, decrement, both subtraction orders, AND and OR. Subtraction and OR follow from two's-complement and De Morgan identities, not from dedicated logic.

Alongside the result, the block reports whether the result is zero and whether it is negative. The adder is a chain of fixed-width slices that pass a ripple carry. The zero flag is formed by a grouped reduction. Both the slice width and the group width are parameters.

Top module: `zn_alu`

## Requirements
- R1: `ctrl_word` bit 5 zeroes X, bit 4 inverts X, bit 3 zeroes Y, bit 2 inverts Y, bit 1 selects the core function (1 = sum, 0 = AND), and bit 0 inverts the result.
- R2: For each operand, zeroing is applied before inversion. Setting both the zero and the invert bit of an operand gives all ones.
- R3: With bit 1 set, the core gives the sum of the conditioned operands modulo 2^WIDTH. The carry-in is zero and the carry out of the top bit is dropped.
- R4: With bit 1 clear, the core gives the bitwise AND of the conditioned operands.
- R5: With bit 0 set, every bit of the core result is inverted to form `result`. With bit 0 clear, the core result passes through unchanged.
- R6: `is_zero` is 1 exactly when every bit of `result` is 0.
- R7: `is_neg` equals the most significant bit of `result`, so it is never 1 together with `is_zero`.
- R8: The arithmetic control words give these results: 000010 gives X+Y, 010011 gives X-Y, 000111 gives Y-X, 001111 gives -X, and 110011 gives -Y. All are taken modulo 2^WIDTH.
- R9: The constant words give a fixed result whatever the operands are: 101010 gives 0, 111111 gives 1, and 111010 gives all ones.
- R10: The pass words give these results: 001100 gives X, 110000 gives Y, 001101 gives the bitwise NOT of X, and 110001 gives the bitwise NOT of Y.
- R11: The step words give these results: 011111 gives X+1, 110111 gives Y+1, 001110 gives X-1, and 110010 gives Y-1.
- R12: The logic words give these results: 000000 gives X AND Y, and 010101 gives X OR Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | WIDTH | First data operand (X) |
| y_in | input | WIDTH | Second data operand (Y) |
| ctrl_word | input | 6 | Control word; its bit assignment is given in R1 |
| result | output | WIDTH | Conditioned, combined and optionally inverted result |
| is_zero | output | 1 | High when `result` is all zeros |
| is_neg | output | 1 | Most significant bit of `result` |

## Verification
The bench builds two copies of the block. The first uses the default 16-bit width with 4-bit adder slices and 8-bit zero groups. On that copy, the bench drives all 18 named control words over the boundary operands 0, 1, 0x7FFF, 0x8000 and 0xFFFF and over random operands, and it adds directed checks of single control bits and of carries that cross slice boundaries. The second copy uses WIDTH=4 with 2-bit slices and 2-bit zero groups. That small configuration brings every one of the 64 control words, together with every operand pair, within an exhaustive sweep. The sweep exercises all carry paths between the slices and every grouping of the zero detector.

// File: rtl/zn_alu_pkg.sv
package zn_alu_pkg;

    localparam int CTRL_W = 6;

    // Field order follows the control word bit order, most significant first.
    typedef struct packed {
        logic zero_x;
        logic inv_x;
        logic zero_y;
        logic inv_y;
        logic use_sum;
        logic inv_out;
    } alu_ctrl_t;

endpackage

// File: rtl/zn_operand_cond.sv
module zn_operand_cond #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd,
    input  logic             force_zero,
    input  logic             flip,
    output logic [WIDTH-1:0] conditioned
);

    logic [WIDTH-1:0] gated;

    // Zeroing comes first, then the conditional inversion.
    always_comb begin
        gated       = force_zero ? '0 : opnd;
        conditioned = gated ^ {WIDTH{flip}};
    end

endmodule

// File: rtl/zn_core_func.sv
module zn_core_func #(
    parameter int WIDTH   = 16,
    parameter int SLICE_W = 4
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    input  logic             use_sum,
    output logic [WIDTH-1:0] core_out
);

    localparam int NSLICE = WIDTH / SLICE_W;

    logic [WIDTH-1:0]  sum_v;
    logic [WIDTH-1:0]  and_v;
    logic [NSLICE-1:0] carry;

    assign carry[0] = 1'b0;
    assign and_v    = a_val & b_val;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        if (s < NSLICE - 1) begin : g_mid
            logic [SLICE_W:0] part;
            assign part = {1'b0, a_val[s*SLICE_W +: SLICE_W]}
                        + {1'b0, b_val[s*SLICE_W +: SLICE_W]}
                        + {{SLICE_W{1'b0}}, carry[s]};
            assign sum_v[s*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
            assign carry[s+1] = part[SLICE_W];
        end else begin : g_top
            // The top slice drops its carry out.
            assign sum_v[s*SLICE_W +: SLICE_W] = a_val[s*SLICE_W +: SLICE_W]
                                               + b_val[s*SLICE_W +: SLICE_W]
                                               + {{(SLICE_W-1){1'b0}}, carry[s]};
        end
    end

    assign core_out = use_sum ? sum_v : and_v;

endmodule

// File: rtl/zn_out_stage.sv
module zn_out_stage #(
    parameter int WIDTH = 16,
    parameter int ZGRP  = 8
) (
    input  logic [WIDTH-1:0] core_val,
    input  logic             inv_out,
    output logic [WIDTH-1:0] result,
    output logic             is_zero,
    output logic             is_neg
);

    localparam int NGRP = WIDTH / ZGRP;

    logic [NGRP-1:0] grp_any;

    assign result = core_val ^ {WIDTH{inv_out}};

    for (genvar g = 0; g < NGRP; g++) begin : g_zgrp
        assign grp_any[g] = |result[g*ZGRP +: ZGRP];
    end

    assign is_zero = ~|grp_any;
    assign is_neg  = result[WIDTH-1];

endmodule

// File: rtl/zn_alu.sv
module zn_alu
    import zn_alu_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int SLICE_W = 4,
    parameter int ZGRP    = 8
) (
    input  logic [WIDTH-1:0]  x_in,
    input  logic [WIDTH-1:0]  y_in,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic [WIDTH-1:0]  result,
    output logic              is_zero,
    output logic              is_neg
);

    alu_ctrl_t        cw;
    logic [WIDTH-1:0] x_cond;
    logic [WIDTH-1:0] y_cond;
    logic [WIDTH-1:0] core_res;

    assign cw = alu_ctrl_t'(ctrl_word);

    zn_operand_cond #(.WIDTH(WIDTH)) u_cond_x (
        .opnd        (x_in),
        .force_zero  (cw.zero_x),
        .flip        (cw.inv_x),
        .conditioned (x_cond)
    );

    zn_operand_cond #(.WIDTH(WIDTH)) u_cond_y (
        .opnd        (y_in),
        .force_zero  (cw.zero_y),
        .flip        (cw.inv_y),
        .conditioned (y_cond)
    );

    zn_core_func #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) u_core (
        .a_val    (x_cond),
        .b_val    (y_cond),
        .use_sum  (cw.use_sum),
        .core_out (core_res)
    );

    zn_out_stage #(.WIDTH(WIDTH), .ZGRP(ZGRP)) u_out (
        .core_val (core_res),
        .inv_out  (cw.inv_out),
        .result   (result),
        .is_zero  (is_zero),
        .is_neg   (is_neg)
    );

endmodule

// File: rtl/zn_alu_chk.sv
module zn_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic [5:0]       ctrl_word,
    input logic [WIDTH-1:0] x_cond,
    input logic [WIDTH-1:0] y_cond,
    input logic [WIDTH-1:0] core_res,
    input logic [WIDTH-1:0] result,
    input logic             is_zero,
    input logic             is_neg
);

    logic [WIDTH-1:0] plain_sum;

    always_comb begin
        plain_sum = x_cond + y_cond;
        if (ctrl_word[5] && !ctrl_word[4]) AST_X_ZEROED: assert (x_cond == '0);    // R2
        if (ctrl_word[5] &&  ctrl_word[4]) AST_X_ALL_ONES: assert (x_cond == '1);  // R2
        if (ctrl_word[3] && !ctrl_word[2]) AST_Y_ZEROED: assert (y_cond == '0);    // R2
        if (ctrl_word[3] &&  ctrl_word[2]) AST_Y_ALL_ONES: assert (y_cond == '1);  // R2
        if (ctrl_word[1]) AST_CORE_SUM: assert (core_res == plain_sum);            // R3
        if (!ctrl_word[1]) AST_CORE_AND: assert (core_res == (x_cond & y_cond));   // R4
        AST_OUT_INVERT: assert ((result ^ core_res) == {WIDTH{ctrl_word[0]}});     // R5
        AST_ZERO_FLAG: assert (is_zero == (result == '0));                         // R6
        AST_NEG_NOT_ZERO: assert (!(is_neg && is_zero));                           // R7
    end

endmodule

bind zn_alu zn_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .ctrl_word (ctrl_word),
    .x_cond    (x_cond),
    .y_cond    (y_cond),
    .core_res  (core_res),
    .result    (result),
    .is_zero   (is_zero),
    .is_neg    (is_neg)
);

// File: tb/zn_alu_test.sv
module zn_alu_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [15:0] x16 = '0, y16 = '0, r16;
    logic [5:0]  c16 = '0;
    logic        z16, n16;
    logic [3:0]  x4 = '0, y4 = '0, r4;
    logic [5:0]  c4 = '0;
    logic        z4, n4;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    zn_alu #(.WIDTH(16), .SLICE_W(4), .ZGRP(8)) uut (
        .x_in(x16), .y_in(y16), .ctrl_word(c16),
        .result(r16), .is_zero(z16), .is_neg(n16)
    );

    zn_alu #(.WIDTH(4), .SLICE_W(2), .ZGRP(2)) uut_n4 (
        .x_in(x4), .y_in(y4), .ctrl_word(c4),
        .result(r4), .is_zero(z4), .is_neg(n4)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    // Bit-level definition from R1..R5.
    function automatic logic [31:0] ref_bits(logic [5:0] c, logic [31:0] x, logic [31:0] y, int w);
        logic [31:0] m, a, b, r;
        m = (32'd1 << w) - 32'd1;
        a = c[5] ? 32'd0 : x;
        if (c[4]) a = ~a;
        b = c[3] ? 32'd0 : y;
        if (c[2]) b = ~b;
        a = a & m;
        b = b & m;
        r = c[1] ? (a + b) : (a & b);
        if (c[0]) r = ~r;
        return r & m;
    endfunction

    function automatic logic [5:0] op_word(int i);
        case (i)
            0: return 6'b101010;  1: return 6'b111111;  2: return 6'b111010;
            3: return 6'b001100;  4: return 6'b110000;  5: return 6'b001101;
            6: return 6'b110001;  7: return 6'b001111;  8: return 6'b110011;
            9: return 6'b011111; 10: return 6'b110111; 11: return 6'b001110;
           12: return 6'b110010; 13: return 6'b000010; 14: return 6'b010011;
           15: return 6'b000111; 16: return 6'b000000; default: return 6'b010101;
        endcase
    endfunction

    // Arithmetic meaning of each named operation, from R8..R12.
    function automatic logic [15:0] op_value(int i, logic [15:0] x, logic [15:0] y);
        case (i)
            0: return 16'd0;       1: return 16'd1;       2: return 16'hFFFF;
            3: return x;           4: return y;           5: return ~x;
            6: return ~y;          7: return 16'd0 - x;   8: return 16'd0 - y;
            9: return x + 16'd1;  10: return y + 16'd1;  11: return x - 16'd1;
           12: return y - 16'd1;  13: return x + y;      14: return x - y;
           15: return y - x;      16: return x & y;      default: return x | y;
        endcase
    endfunction

    function automatic string op_tag(int i);
        if (i <= 2) return "R9";
        if (i <= 6) return "R10";
        if (i == 7 || i == 8 || (i >= 13 && i <= 15)) return "R8";
        if (i <= 12) return "R11";
        return "R12";
    endfunction

    task automatic apply16(input logic [5:0] c, input logic [15:0] x, input logic [15:0] y);
        c16 = c; x16 = x; y16 = y;
        @(negedge clk);
    endtask

    task automatic check_op16(int i, logic [15:0] x, logic [15:0] y);
        logic [15:0] e;
        e = op_value(i, x, y);
        apply16(op_word(i), x, y);
        chk(op_tag(i), {16'd0, r16}, {16'd0, e});
        chk("R6", {31'd0, z16}, {31'd0, (e == 16'd0)});
        chk("R7", {31'd0, n16}, {31'd0, e[15]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] bnd [5];
        bnd[0] = 16'h0000; bnd[1] = 16'h0001; bnd[2] = 16'h7FFF;
        bnd[3] = 16'h8000; bnd[4] = 16'hFFFF;

        // Initial state: all-zero inputs, AND of zeros.
        @(negedge clk);
        chk("R12 idle", {16'd0, r16}, 32'd0);
        chk("R6 idle", {31'd0, z16}, 32'd1);
        chk("R7 idle", {31'd0, n16}, 32'd0);

        // Worked examples.
        apply16(6'b000010, 16'd5, 16'd3);
        chk("R8 5+3", {16'd0, r16}, 32'd8);
        chk("R6 5+3", {31'd0, z16}, 32'd0);
        chk("R7 5+3", {31'd0, n16}, 32'd0);
        apply16(6'b001111, 16'd5, 16'h1234);
        chk("R8 -5", {16'd0, r16}, 32'hFFFB);
        chk("R7 -5", {31'd0, n16}, 32'd1);
        apply16(6'b010011, 16'd5, 16'd3);
        chk("R8 5-3", {16'd0, r16}, 32'd2);
        apply16(6'b010101, 16'h000C, 16'h000A);
        chk("R12 C|A", {16'd0, r16}, 32'h000E);

        // Single control bits (R1, R2, R4, R5).
        apply16(6'b100000, 16'h1234, 16'hFFFF);
        chk("R1 zero X", {16'd0, r16}, 32'd0);
        apply16(6'b010000, 16'h00F0, 16'hFFFF);
        chk("R1 invert X", {16'd0, r16}, 32'hFF0F);
        apply16(6'b001000, 16'hFFFF, 16'h5A5A);
        chk("R1 zero Y", {16'd0, r16}, 32'd0);
        apply16(6'b000100, 16'hFFFF, 16'h00F0);
        chk("R1 invert Y", {16'd0, r16}, 32'hFF0F);
        apply16(6'b110000, 16'h0000, 16'hA5C3);
        chk("R2 zero then invert X", {16'd0, r16}, 32'hA5C3);
        apply16(6'b000000, 16'hF0F0, 16'hCC33);
        chk("R4 and", {16'd0, r16}, 32'hC030);
        apply16(6'b000001, 16'hF0F0, 16'hCC33);
        chk("R5 inverted and", {16'd0, r16}, 32'h3FCF);

        // Carry handling (R3).
        apply16(6'b000010, 16'hFFFF, 16'h0001);
        chk("R3 carry dropped", {16'd0, r16}, 32'd0);
        chk("R6 wrap zero", {31'd0, z16}, 32'd1);
        apply16(6'b000010, 16'h0FFF, 16'h0001);
        chk("R3 slice ripple", {16'd0, r16}, 32'h1000);
        apply16(6'b000010, 16'h7FFF, 16'h0001);
        chk("R3 into msb", {16'd0, r16}, 32'h8000);
        chk("R7 msb set", {31'd0, n16}, 32'd1);

        // Named operations over boundary and random operands.
        for (int i = 0; i < 18; i++) begin
            for (int a = 0; a < 5; a++)
                for (int b = 0; b < 5; b++)
                    check_op16(i, bnd[a], bnd[b]);
            for (int k = 0; k < 20; k++) begin
                logic [31:0] rv;
                rv = $urandom;
                check_op16(i, rv[15:0], rv[31:16]);
            end
        end

        // Exhaustive sweep of the 4-bit copy over every control word.
        for (int c = 0; c < 64; c++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    logic [31:0] e;
                    c4 = 6'(c); x4 = 4'(x); y4 = 4'(y);
                    @(negedge clk);
                    e = ref_bits(6'(c), 32'(x), 32'(y), 4);
                    chk("R1 R2 R3 R4 R5 sweep", {28'd0, r4}, e);
                    chk("R6 sweep", {31'd0, z4}, {31'd0, (e == 32'd0)});
                    chk("R7 sweep", {31'd0, n4}, {31'd0, e[3]});
                end
            end
        end

        finish_run();
    end

endmodule